// File: doc/BRIEF.md
# Modulo-60 Periodic Alarm Timer

This block is a wake-up counter driven by a prescaled tick. Software loads the count value, turns the timer on and off, and chooses an alarm offset. Next to the main count it keeps a phase counter that runs from 0 to 59. That phase restarts at a fresh modulo-60 boundary whenever software loads a new count, and whenever the timer is switched from off to on.

When the phase advances onto the programmed offset, a sticky alarm status bit is set. Because the phase wraps every 60 ticks, the alarm repeats with a period of 60 prescaled units. An offset above 59 is treated as 0. The status bit drives the interrupt line only while the alarm interrupt enable is set, and software clears the status bit by pulsing a write-1 clear strobe.

Top module: `mod60_alarm_timer`

## Requirements
- R1: Out of reset, the count is 0, the phase is 0, the status and interrupt are 0, the timer is disabled, the interrupt enable is 0 and the offset reads 30.
- R2: The count rises by exactly one on each cycle where `tick_i` is high and the timer is enabled. It does not change on a tick while the timer is disabled, and it wraps from all ones to 0.
- R3: The phase advances together with the count, stays within 0..59, and goes from 59 to 0.
- R4: A count load (`cnt_wr_i`) sets the count to `cnt_wdata_i` and the phase to 0 at the next edge. A load takes priority over a tick in the same cycle.
- R5: A configuration write that turns the timer from disabled to enabled sets the phase to 0 and leaves the count unchanged.
- R6: The status bit is set on the tick where the phase steps onto the effective offset. For an offset of 30 this is the 30th tick after a boundary, and it happens again every 60 ticks after that.
- R7: A programmed offset of 60 to 63 behaves as 0: the status bit is set on the 60th tick after a boundary, when the phase wraps to 0. The register still reads back the raw value.
- R8: The status bit stays set until `sts_clr_i` is pulsed high. If a set and a clear fall in the same cycle, the set wins.
- R9: `irq_o` is high exactly when the status bit is set and the interrupt enable is 1.
- R10: `cfg_wr_i` writes the enable, the interrupt enable and the 6-bit offset together, and `en_o`, `irq_en_o` and `ofs_o` show the written values from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescaled time-unit strobe |
| cnt_wr_i | input | 1 | Count load strobe |
| cnt_wdata_i | input | CNT_W | Value to load into the count |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_en_i | input | 1 | Timer enable value to write |
| cfg_irq_en_i | input | 1 | Alarm interrupt enable value to write |
| cfg_ofs_i | input | 6 | Alarm offset value to write |
| sts_clr_i | input | 1 | Write-1 clear of the alarm status |
| cnt_o | output | CNT_W | Current count |
| phase_o | output | 6 | Current modulo-60 phase |
| en_o | output | 1 | Timer enable |
| irq_en_o | output | 1 | Alarm interrupt enable |
| ofs_o | output | 6 | Programmed offset, as written |
| sts_o | output | 1 | Sticky alarm status |
| irq_o | output | 1 | Gated alarm interrupt |

## Verification
The hardest case to reach from the ports is a clear strobe that arrives on the same tick that sets the status again. That tick is a whole period away from the previous alarm. To get there, the stimulus uses an offset of 1, lets the first alarm set the status, runs 59 more ticks so the phase is one step from the offset, and then raises the clear together with the next tick. A second hard case is a load or an enable that arrives in the middle of a period. The stimulus moves the phase away from zero first, so the restart of the boundary, and the 30-tick wait that follows it, can be seen at the outputs.

// File: rtl/mod60_pkg.sv
package mod60_pkg;
  localparam int unsigned PERIOD  = 60;
  localparam int unsigned PH_W    = $clog2(PERIOD);
  localparam int unsigned OFS_RST = 30;
  typedef logic [PH_W-1:0] phase_t;
endpackage

// File: rtl/mod60_count.sv
module mod60_count #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (ld_i)  cnt_q <= ld_val_i;
    else if (adv_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !ld_i) |=> $stable(cnt_o)); // R2
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !ld_i) |=> cnt_o == $past(cnt_o) + 1'b1); // R2
endmodule

// File: rtl/mod60_phase.sv
module mod60_phase
  import mod60_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   adv_i,
  input  logic   restart_i,
  input  phase_t ofs_raw_i,
  output phase_t phase_o,
  output logic   hit_o
);
  phase_t phase_q, phase_nxt, ofs_eff;

  // offsets past the period fold to zero
  assign ofs_eff   = (ofs_raw_i >= phase_t'(PERIOD)) ? '0 : ofs_raw_i;
  assign phase_nxt = (phase_q == phase_t'(PERIOD - 1)) ? '0 : phase_q + 1'b1;
  assign hit_o     = adv_i && !restart_i && (phase_nxt == ofs_eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        phase_q <= '0;
    else if (restart_i) phase_q <= '0;
    else if (adv_i)     phase_q <= phase_nxt;
  end

  assign phase_o = phase_q;

  AST_PHASE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o < phase_t'(PERIOD)); // R3
  AST_PHASE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> phase_o == '0); // R4
  AST_PHASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !restart_i) |=> $stable(phase_o)); // R3
endmodule

// File: rtl/mod60_alarm.sv
module mod60_alarm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic clr_i,
  input  logic irq_en_i,
  output logic sts_o,
  output logic irq_o
);
  logic sts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sts_q <= 1'b0;
    else if (hit_i) sts_q <= 1'b1;
    else if (clr_i) sts_q <= 1'b0;
  end

  assign sts_o = sts_q;
  assign irq_o = sts_q & irq_en_i;

  AST_STS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> sts_o); // R6
  AST_STS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_o && !clr_i) |=> sts_o); // R8
  AST_STS_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sts_o && !hit_i) |=> !sts_o); // R6
endmodule

// File: rtl/mod60_alarm_timer.sv
module mod60_alarm_timer
  import mod60_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             cfg_wr_i,
  input  logic             cfg_en_i,
  input  logic             cfg_irq_en_i,
  input  logic [5:0]       cfg_ofs_i,
  input  logic             sts_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [5:0]       phase_o,
  output logic             en_o,
  output logic             irq_en_o,
  output logic [5:0]       ofs_o,
  output logic             sts_o,
  output logic             irq_o
);
  logic   en_q, irq_en_q;
  phase_t ofs_q;
  logic   adv, en_rise, restart, hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      irq_en_q <= 1'b0;
      ofs_q    <= phase_t'(OFS_RST);
    end else if (cfg_wr_i) begin
      en_q     <= cfg_en_i;
      irq_en_q <= cfg_irq_en_i;
      ofs_q    <= cfg_ofs_i;
    end
  end

  assign adv     = en_q & tick_i;
  assign en_rise = cfg_wr_i & cfg_en_i & ~en_q;
  assign restart = cnt_wr_i | en_rise;

  mod60_count #(.CNT_W(CNT_W)) u_count (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (adv),
    .ld_i     (cnt_wr_i),
    .ld_val_i (cnt_wdata_i),
    .cnt_o    (cnt_o)
  );

  mod60_phase u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (adv),
    .restart_i (restart),
    .ofs_raw_i (ofs_q),
    .phase_o   (phase_o),
    .hit_o     (hit)
  );

  mod60_alarm u_alarm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hit_i    (hit),
    .clr_i    (sts_clr_i),
    .irq_en_i (irq_en_q),
    .sts_o    (sts_o),
    .irq_o    (irq_o)
  );

  assign en_o     = en_q;
  assign irq_en_o = irq_en_q;
  assign ofs_o    = ofs_q;

  AST_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr_i |=> (cnt_o == $past(cnt_wdata_i)) && (phase_o == '0)); // R4
  AST_EN_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_rise && !cnt_wr_i) |=> (phase_o == '0) && $stable(cnt_o)); // R5
  AST_IRQ_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (sts_o && irq_en_o)); // R9
  AST_OFF_NO_ALARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_o && !sts_o) |=> !sts_o); // R2
endmodule

// File: tb/tb_mod60_alarm_timer.sv
module tb_mod60_alarm_timer;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 32;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic tick_i = 0, cnt_wr_i = 0, cfg_wr_i = 0, cfg_en_i = 0, cfg_irq_en_i = 0, sts_clr_i = 0;
  logic [CNT_W-1:0] cnt_wdata_i = '0;
  logic [5:0] cfg_ofs_i = '0;
  logic [CNT_W-1:0] cnt_o;
  logic [5:0] phase_o, ofs_o;
  logic en_o, irq_en_o, sts_o, irq_o;

  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mod60_alarm_timer #(.CNT_W(CNT_W)) dut (.*);

  task automatic chk(string req, string what, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0;
    step();
    rst_ni = 1;
    step();
  endtask

  task automatic cfg(logic en, logic ie, logic [5:0] ofs);
    cfg_wr_i = 1; cfg_en_i = en; cfg_irq_en_i = ie; cfg_ofs_i = ofs;
    step();
    cfg_wr_i = 0;
  endtask

  task automatic load(logic [CNT_W-1:0] v);
    cnt_wr_i = 1; cnt_wdata_i = v;
    step();
    cnt_wr_i = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1;
      step();
    end
    tick_i = 0;
  endtask

  task automatic clear();
    sts_clr_i = 1;
    step();
    sts_clr_i = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "cnt", cnt_o, 0);
    chk("R1", "phase", phase_o, 0);
    chk("R1", "sts", sts_o, 0);
    chk("R1", "irq", irq_o, 0);
    chk("R1", "en", en_o, 0);
    chk("R1", "irq_en", irq_en_o, 0);
    chk("R1", "ofs", ofs_o, 30);
  endtask

  task automatic t_count();
    do_reset();
    ticks(5);
    chk("R2", "cnt while off", cnt_o, 0);
    cfg(1, 0, 30);
    chk("R10", "en readback", en_o, 1);
    ticks(7);
    chk("R2", "cnt after 7", cnt_o, 7);
    chk("R3", "phase after 7", phase_o, 7);
    load('1);
    ticks(1);
    chk("R2", "cnt wrap", cnt_o, 0);
    chk("R3", "phase 1 after wrap", phase_o, 1);
    ticks(58);
    chk("R3", "phase 59", phase_o, 59);
    ticks(1);
    chk("R3", "phase wraps", phase_o, 0);
  endtask

  task automatic t_alarm30();
    do_reset();
    cfg(1, 1, 30);
    ticks(29);
    chk("R6", "no sts at 29", sts_o, 0);
    ticks(1);
    chk("R6", "sts at 30", sts_o, 1);
    chk("R9", "irq with enable", irq_o, 1);
    clear();
    chk("R8", "cleared", sts_o, 0);
    ticks(59);
    chk("R6", "no sts at 89", sts_o, 0);
    ticks(1);
    chk("R6", "sts at 90", sts_o, 1);
    chk("R2", "cnt 90", cnt_o, 90);
  endtask

  task automatic t_fold();
    do_reset();
    cfg(1, 0, 6'd63);
    chk("R10", "raw ofs readback", ofs_o, 63);
    ticks(59);
    chk("R7", "no sts before wrap", sts_o, 0);
    ticks(1);
    chk("R7", "sts at wrap", sts_o, 1);
    chk("R7", "phase at fire", phase_o, 0);
  endtask

  task automatic t_load();
    do_reset();
    cfg(1, 0, 30);
    ticks(20);
    load(1000);
    chk("R4", "cnt loaded", cnt_o, 1000);
    chk("R4", "phase reset", phase_o, 0);
    ticks(29);
    chk("R4", "no sts 29 after load", sts_o, 0);
    ticks(1);
    chk("R4", "sts 30 after load", sts_o, 1);
    tick_i = 1; cnt_wr_i = 1; cnt_wdata_i = 77;
    step();
    tick_i = 0; cnt_wr_i = 0;
    chk("R4", "load beats tick cnt", cnt_o, 77);
    chk("R4", "load beats tick phase", phase_o, 0);
  endtask

  task automatic t_enable();
    do_reset();
    cfg(1, 0, 30);
    ticks(10);
    cfg(0, 0, 30);
    ticks(3);
    chk("R2", "cnt held off", cnt_o, 10);
    chk("R3", "phase held off", phase_o, 10);
    cfg(1, 0, 30);
    chk("R5", "phase restart", phase_o, 0);
    chk("R5", "cnt kept", cnt_o, 10);
    ticks(29);
    chk("R5", "no sts 29 after enable", sts_o, 0);
    ticks(1);
    chk("R5", "sts 30 after enable", sts_o, 1);
  endtask

  task automatic t_irq();
    do_reset();
    cfg(1, 0, 2);
    ticks(2);
    chk("R9", "sts set", sts_o, 1);
    chk("R9", "irq gated off", irq_o, 0);
    cfg(1, 1, 2);
    chk("R10", "irq_en readback", irq_en_o, 1);
    chk("R9", "irq on", irq_o, 1);
    clear();
    chk("R9", "irq off after clear", irq_o, 0);
  endtask

  task automatic t_set_wins();
    do_reset();
    cfg(1, 0, 1);
    ticks(1);
    chk("R6", "sts at 1", sts_o, 1);
    ticks(59);
    chk("R8", "sticky over period", sts_o, 1);
    chk("R8", "phase 0", phase_o, 0);
    tick_i = 1; sts_clr_i = 1;
    step();
    tick_i = 0; sts_clr_i = 0;
    chk("R8", "set wins over clear", sts_o, 1);
    clear();
    chk("R8", "clear alone", sts_o, 0);
  endtask

  initial begin
    t_reset();
    t_count();
    t_alarm30();
    t_fold();
    t_load();
    t_enable();
    t_irq();
    t_set_wins();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule